// File: doc/BRIEF.md
# Masked Dual-Source Interrupt Controller

This block merges two interrupt sources into a single processor interrupt request. Each source has its own sticky status register and its own mask. The first source is a general-purpose interrupt controller, fed by numbered peripheral request lines. The second source is the interrupt unit of a DMA controller. Its status and its mask share one 32-bit word: the status sits in the low half and the matching mask bits sit in the high half. One DMA status bit, the top bit of the low half, raises an interrupt whatever its mask bit holds.

Software works on the registers through a small word-wide write port and a combinational read port. Writing 1 to a status bit clears that bit. Writing 1 to a mask bit inverts it. A DMA-enable register and a global DMA-on input can hold DMA interrupts back. This covers both a disabled controller and a suspended one.

The block presents a request flag and a 12-bit vector code to the processor. A general interrupt takes precedence over a DMA interrupt. When the processor acknowledges while status bit 1 of the general controller is pending and a general interrupt is being presented, the block emits a one-cycle strobe. The timers use this strobe to latch their counts.

Top module: `intc_dual_source`

## Requirements
- R1: Request line n of either source (gen_req[n], dma_req[n]) held high at a clock edge sets status bit n, which then stays set until cleared. A request and a clear of the same bit at the same edge leave the bit set.
- R2: A register write to address 0 clears each general status bit whose data bit is 1. A register write to address 2 clears each DMA status bit n (0 to 15) whose data bit n is 1. Data bits of 0 leave status unchanged.
- R3: A register write to address 1 inverts each general mask bit whose data bit is 1. A register write to address 2 inverts each DMA mask bit n whose data bit n+16 is 1. Data bits of 0 leave the mask unchanged.
- R4: irq_valid is high with irq_vector = 0x400 whenever the general status ANDed with the general mask is nonzero.
- R5: When no general interrupt is pending, irq_valid is high with irq_vector = 0x800 if the DMA status ANDed with the DMA mask is nonzero (or R6 applies) and the DMA unit is not held off (R7). With nothing valid, irq_vector is 0.
- R6: DMA status bit 15 produces a DMA interrupt even when DMA mask bit 15 is clear.
- R7: DMA interrupts are suppressed while dma_on is 0, or while bits 23:16 of the enable register equal 0x01 (suspend).
- R8: If a general interrupt and a DMA interrupt are both pending, the vector is 0x400.
- R9: timer_capture is high for exactly the cycle after a cycle in which irq_ack was high, a general interrupt was presented, and general status bit 1 was set. Otherwise it is low.
- R10: After reset, all status and mask bits are 0, the enable register holds 0x00001201, irq_valid and timer_capture are 0, and irq_vector is 0.
- R11: The read data is selected by reg_addr as follows. Address 0 returns the general status, zero-extended. Address 1 returns the general mask, zero-extended. Address 2 returns {DMA mask, DMA status}. Address 3 returns the enable register. A write to address 3 loads all 32 bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| gen_req | input | GEN_LINES | General-controller request lines |
| dma_req | input | 16 | DMA-unit request lines |
| dma_on | input | 1 | Global DMA-enable control bit |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register address for reads and writes |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational) |
| irq_ack | input | 1 | Processor takes the presented interrupt |
| irq_valid | output | 1 | Interrupt request to the processor |
| irq_vector | output | 12 | Vector code: 0x400 general, 0x800 DMA, 0 none |
| timer_capture | output | 1 | One-cycle strobe telling timers 0 and 1 to latch |

## Verification
A corrupted status or mask bit shows up at irq_valid and irq_vector in the cycle after the edge that stored it. It also shows up on the read port as soon as the matching address is selected. The bench therefore compares the read data, the request flag and the vector against a register-level model after every edge, so a fault is caught in the cycle where it first shows. A fault in the suspend decode or the bypass bit only shows at the outputs while a DMA bit is pending and no general interrupt is pending. The directed cases set up exactly that state. A wrong capture condition shows one cycle after an acknowledge.

// File: rtl/intc_pkg.sv
package intc_pkg;
  localparam int REG_W    = 32;
  localparam int HALF_W   = REG_W / 2;
  localparam int VEC_W    = 12;
  localparam logic [VEC_W-1:0] VEC_GEN  = 12'h400;
  localparam logic [VEC_W-1:0] VEC_DMA  = 12'h800;
  localparam logic [VEC_W-1:0] VEC_NONE = 12'h000;
  localparam logic [REG_W-1:0] EN_RESET = 32'h0000_1201;
  localparam logic [7:0]       SUSPEND_CODE = 8'h01;
  localparam int BYPASS_BIT  = HALF_W - 1;
  localparam int CAPTURE_BIT = 1;

  typedef enum logic [1:0] {
    ADDR_GSTAT  = 2'd0,
    ADDR_GMASK  = 2'd1,
    ADDR_DWORD  = 2'd2,
    ADDR_ENABLE = 2'd3
  } reg_addr_e;
endpackage

// File: rtl/irq_status_bank.sv
module irq_status_bank #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] set_i,
  input  logic         clr_en_i,
  input  logic [W-1:0] clr_bits_i,
  input  logic         tog_en_i,
  input  logic [W-1:0] tog_bits_i,
  output logic [W-1:0] stat_o,
  output logic [W-1:0] mask_o
);
  logic [W-1:0] stat_q, stat_d;
  logic [W-1:0] mask_q, mask_d;
  logic         stat_upd;

  for (genvar b = 0; b < W; b++) begin : g_bit
    assign stat_d[b] = set_i[b] | (stat_q[b] & ~(clr_en_i & clr_bits_i[b]));
    assign mask_d[b] = mask_q[b] ^ (tog_en_i & tog_bits_i[b]);
  end

  assign stat_upd = clr_en_i | (|set_i);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stat_q <= '0;
      mask_q <= '0;
    end else begin
      if (stat_upd) stat_q <= stat_d;
      if (tog_en_i) mask_q <= mask_d;
    end
  end

  assign stat_o = stat_q;
  assign mask_o = mask_q;

  // R1: a sampled request leaves its status bit set
  assert_set_sticky_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (|set_i) |=> ((stat_o & $past(set_i)) == $past(set_i)));

  // R2: without a clear, no status bit drops
  assert_no_drop_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !clr_en_i |=> ((stat_o & $past(stat_o)) == $past(stat_o)));

  // R2: cleared bits without a concurrent request are zero afterwards
  assert_clear_done_R2: assert property (@(posedge clk) disable iff (!rst_n)
    clr_en_i |=> ((stat_o & $past(clr_bits_i & ~set_i)) == '0));

  // R3: mask only moves on a toggle write
  assert_mask_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !tog_en_i |=> $stable(mask_o));
endmodule

// File: rtl/irq_vector_select.sv
module irq_vector_select
  import intc_pkg::*;
#(
  parameter int GW = 16
) (
  input  logic [GW-1:0]     gen_stat_i,
  input  logic [GW-1:0]     gen_mask_i,
  input  logic [HALF_W-1:0] dma_stat_i,
  input  logic [HALF_W-1:0] dma_mask_i,
  input  logic              dma_allowed_i,
  output logic              gen_hit_o,
  output logic              irq_valid_o,
  output logic [VEC_W-1:0]  irq_vector_o
);
  logic dma_pending;
  logic dma_hit;

  always_comb begin
    gen_hit_o   = |(gen_stat_i & gen_mask_i);
    dma_pending = (|(dma_stat_i & dma_mask_i)) | dma_stat_i[BYPASS_BIT];
    dma_hit     = dma_pending & dma_allowed_i;
    irq_valid_o = gen_hit_o | dma_hit;
    if (gen_hit_o)    irq_vector_o = VEC_GEN;
    else if (dma_hit) irq_vector_o = VEC_DMA;
    else              irq_vector_o = VEC_NONE;
  end
endmodule

// File: rtl/intc_dual_source.sv
module intc_dual_source
  import intc_pkg::*;
#(
  parameter int GEN_LINES = 16
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [GEN_LINES-1:0] gen_req,
  input  logic [15:0]          dma_req,
  input  logic                 dma_on,
  input  logic                 reg_wr,
  input  logic [1:0]           reg_addr,
  input  logic [31:0]          reg_wdata,
  output logic [31:0]          reg_rdata,
  input  logic                 irq_ack,
  output logic                 irq_valid,
  output logic [11:0]          irq_vector,
  output logic                 timer_capture
);
  localparam int PAD_W = REG_W - GEN_LINES;

  logic [GEN_LINES-1:0] gen_stat, gen_mask;
  logic [HALF_W-1:0]    dma_stat, dma_mask;
  logic                 wr_gstat, wr_gmask, wr_dword, wr_enable;
  logic [REG_W-1:0]     en_q, en_d;
  logic                 suspended, dma_allowed, gen_hit;
  logic                 cap_q, cap_d;

  always_comb begin
    wr_gstat  = reg_wr & (reg_addr == ADDR_GSTAT);
    wr_gmask  = reg_wr & (reg_addr == ADDR_GMASK);
    wr_dword  = reg_wr & (reg_addr == ADDR_DWORD);
    wr_enable = reg_wr & (reg_addr == ADDR_ENABLE);
  end

  irq_status_bank #(.W(GEN_LINES)) u_gen_bank (
    .clk        (clk),
    .rst_n      (rst_n),
    .set_i      (gen_req),
    .clr_en_i   (wr_gstat),
    .clr_bits_i (reg_wdata[GEN_LINES-1:0]),
    .tog_en_i   (wr_gmask),
    .tog_bits_i (reg_wdata[GEN_LINES-1:0]),
    .stat_o     (gen_stat),
    .mask_o     (gen_mask)
  );

  irq_status_bank #(.W(HALF_W)) u_dma_bank (
    .clk        (clk),
    .rst_n      (rst_n),
    .set_i      (dma_req),
    .clr_en_i   (wr_dword),
    .clr_bits_i (reg_wdata[HALF_W-1:0]),
    .tog_en_i   (wr_dword),
    .tog_bits_i (reg_wdata[REG_W-1:HALF_W]),
    .stat_o     (dma_stat),
    .mask_o     (dma_mask)
  );

  // enable register: next-state and register processes
  assign en_d = reg_wdata;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         en_q <= EN_RESET;
    else if (wr_enable) en_q <= en_d;
  end

  assign suspended   = (en_q[23:16] == SUSPEND_CODE);
  assign dma_allowed = dma_on & ~suspended;

  irq_vector_select #(.GW(GEN_LINES)) u_select (
    .gen_stat_i    (gen_stat),
    .gen_mask_i    (gen_mask),
    .dma_stat_i    (dma_stat),
    .dma_mask_i    (dma_mask),
    .dma_allowed_i (dma_allowed),
    .gen_hit_o     (gen_hit),
    .irq_valid_o   (irq_valid),
    .irq_vector_o  (irq_vector)
  );

  // timer capture strobe
  assign cap_d = irq_ack & gen_hit & gen_stat[CAPTURE_BIT];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cap_q <= 1'b0;
    else        cap_q <= cap_d;
  end

  assign timer_capture = cap_q;

  // read port
  always_comb begin
    unique case (reg_addr)
      ADDR_GSTAT:  reg_rdata = {{PAD_W{1'b0}}, gen_stat};
      ADDR_GMASK:  reg_rdata = {{PAD_W{1'b0}}, gen_mask};
      ADDR_DWORD:  reg_rdata = {dma_mask, dma_stat};
      default:     reg_rdata = en_q;
    endcase
  end

  // R7: with the DMA unit held off, only the general source can request
  assert_dma_held_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (suspended || !dma_on) && !gen_hit |-> !irq_valid);

  // R9: a capture strobe follows an acknowledged general interrupt
  assert_capture_after_ack_R9: assert property (@(posedge clk) disable iff (!rst_n)
    timer_capture |-> $past(irq_ack && irq_vector == VEC_GEN));

  // R8: a pending general interrupt always wins the vector
  assert_gen_priority_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (|(gen_stat & gen_mask)) |-> (irq_valid && irq_vector == VEC_GEN));
endmodule

// File: tb/test_intc_dual_source.sv
`timescale 1ns/1ps
module test_intc_dual_source;
  localparam int GL = 16;

  logic          clk = 1'b0;
  logic          rst_n;
  logic [GL-1:0] gen_req;
  logic [15:0]   dma_req;
  logic          dma_on;
  logic          reg_wr;
  logic [1:0]    reg_addr;
  logic [31:0]   reg_wdata;
  logic [31:0]   reg_rdata;
  logic          irq_ack;
  logic          irq_valid;
  logic [11:0]   irq_vector;
  logic          timer_capture;

  always #2.5 clk = ~clk;

  intc_dual_source #(.GEN_LINES(GL)) i_intc_dual_source (
    .clk(clk), .rst_n(rst_n), .gen_req(gen_req), .dma_req(dma_req),
    .dma_on(dma_on), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq_ack(irq_ack),
    .irq_valid(irq_valid), .irq_vector(irq_vector),
    .timer_capture(timer_capture)
  );

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  logic [GL-1:0] m_gstat, m_gmask;
  logic [15:0]   m_dstat, m_dmask;
  logic [31:0]   m_en;
  logic          m_cap;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic m_gen_hit();
    return |(m_gstat & m_gmask);
  endfunction

  function automatic logic [11:0] m_vector();
    logic dpend;
    dpend = (|(m_dstat & m_dmask)) | m_dstat[15];
    if (m_gen_hit()) return 12'h400;
    if (dpend && dma_on && (m_en[23:16] != 8'h01)) return 12'h800;
    return 12'h000;
  endfunction

  function automatic logic [31:0] m_read(input logic [1:0] a);
    case (a)
      2'd0: return {{(32-GL){1'b0}}, m_gstat};
      2'd1: return {{(32-GL){1'b0}}, m_gmask};
      2'd2: return {m_dmask, m_dstat};
      default: return m_en;
    endcase
  endfunction

  task automatic check_outputs(input string tag);
    chk({tag, " R4 R5 R8 vector"}, {20'd0, irq_vector}, {20'd0, m_vector()});
    chk({tag, " R4 R5 valid"}, {31'd0, irq_valid}, {31'd0, m_vector() != 12'h000});
    chk({tag, " R9 capture"}, {31'd0, timer_capture}, {31'd0, m_cap});
    chk({tag, " R11 readback"}, reg_rdata, m_read(reg_addr));
  endtask

  task automatic cycle(input logic [GL-1:0] gr, input logic [15:0] dr, input logic on,
                       input logic wr, input logic [1:0] a, input logic [31:0] wd,
                       input logic ack, input string tag);
    @(negedge clk);
    gen_req = gr; dma_req = dr; dma_on = on; reg_wr = wr;
    reg_addr = a; reg_wdata = wd; irq_ack = ack;
    @(posedge clk);
    m_cap = ack && m_gen_hit() && m_gstat[1];
    m_gstat = (m_gstat & ~((wr && a == 2'd0) ? wd[GL-1:0] : '0)) | gr;
    m_gmask = m_gmask ^ ((wr && a == 2'd1) ? wd[GL-1:0] : '0);
    m_dstat = (m_dstat & ~((wr && a == 2'd2) ? wd[15:0] : 16'd0)) | dr;
    m_dmask = m_dmask ^ ((wr && a == 2'd2) ? wd[31:16] : 16'd0);
    if (wr && a == 2'd3) m_en = wd;
    #1;
    check_outputs(tag);
  endtask

  task automatic idle(input logic [1:0] a, input logic on, input string tag);
    cycle('0, 16'd0, on, 1'b0, a, 32'd0, 1'b0, tag);
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired actual=running expected=finished");
      summary();
      $finish;
    end
  end

  initial begin
    logic [31:0] seed;
    seed = $urandom(32'd1234);
    rst_n = 1'b0; gen_req = '0; dma_req = '0; dma_on = 1'b1; reg_wr = 1'b0;
    reg_addr = 2'd0; reg_wdata = '0; irq_ack = 1'b0;
    m_gstat = '0; m_gmask = '0; m_dstat = '0; m_dmask = '0;
    m_en = 32'h0000_1201; m_cap = 1'b0;
    repeat (3) @(posedge clk);
    // R10: reset state seen through every address
    for (int a = 0; a < 4; a++) begin
      reg_addr = a[1:0];
      #1;
      chk("R10 reset readback", reg_rdata, (a == 3) ? 32'h0000_1201 : 32'd0);
    end
    chk("R10 reset valid", {31'd0, irq_valid}, 32'd0);
    chk("R10 reset vector", {20'd0, irq_vector}, 32'd0);
    chk("R10 reset capture", {31'd0, timer_capture}, 32'd0);
    @(negedge clk); rst_n = 1'b1;

    // R1: unmasked request latches without interrupting
    cycle(16'h0008, 16'd0, 1'b1, 1'b0, 2'd0, 32'd0, 1'b0, "R1 set");
    idle(2'd0, 1'b1, "R1 hold");
    chk("R1 sticky bit3", reg_rdata, 32'h0000_0008);
    chk("R1 no irq unmasked", {31'd0, irq_valid}, 32'd0);
    // R3: toggle mask bit 3 on -> general interrupt
    cycle('0, 16'd0, 1'b1, 1'b1, 2'd1, 32'h0000_0008, 1'b0, "R3 toggle on");
    chk("R4 vector 0x400", {20'd0, irq_vector}, 32'h400);
    // R2: writing zeros does not clear
    cycle('0, 16'd0, 1'b1, 1'b1, 2'd0, 32'h0000_0000, 1'b0, "R2 zero write");
    idle(2'd0, 1'b1, "R2 read");
    chk("R2 zero write keeps", reg_rdata, 32'h0000_0008);
    // R1: set wins over a concurrent clear
    cycle(16'h0008, 16'd0, 1'b1, 1'b1, 2'd0, 32'h0000_0008, 1'b0, "R1 set vs clear");
    chk("R1 set wins", reg_rdata, 32'h0000_0008);
    cycle('0, 16'd0, 1'b1, 1'b1, 2'd0, 32'h0000_0008, 1'b0, "R2 clear");
    chk("R2 cleared", reg_rdata, 32'd0);
    // R3: toggle again turns mask off
    cycle('0, 16'd0, 1'b1, 1'b1, 2'd1, 32'h0000_0008, 1'b0, "R3 toggle off");
    chk("R3 mask off", reg_rdata, 32'd0);
    // R6: DMA bit 15 bypasses a clear mask
    cycle('0, 16'h8000, 1'b1, 1'b0, 2'd2, 32'd0, 1'b0, "R6 bypass");
    chk("R6 vector 0x800", {20'd0, irq_vector}, 32'h800);
    // R7: global DMA enable off
    idle(2'd2, 1'b0, "R7 dma off");
    chk("R7 off suppresses", {31'd0, irq_valid}, 32'd0);
    // R7: suspend code in byte 2
    cycle('0, 16'd0, 1'b1, 1'b1, 2'd3, 32'h0001_1201, 1'b0, "R7 suspend");
    chk("R7 suspend suppresses", {31'd0, irq_valid}, 32'd0);
    cycle('0, 16'd0, 1'b1, 1'b1, 2'd3, 32'h0002_1201, 1'b0, "R7 resume");
    chk("R7 other code allows", {20'd0, irq_vector}, 32'h800);
    // R5: masked DMA bit 2 after clearing bit 15
    cycle('0, 16'd0, 1'b1, 1'b1, 2'd2, 32'h0004_8000, 1'b0, "R5 clear and mask");
    cycle('0, 16'h0004, 1'b1, 1'b0, 2'd2, 32'd0, 1'b0, "R5 masked dma");
    chk("R5 masked dma vector", {20'd0, irq_vector}, 32'h800);
    // R8: general wins when both pending
    cycle(16'h0002, 16'd0, 1'b1, 1'b1, 2'd1, 32'h0000_0002, 1'b0, "R8 both");
    chk("R8 priority", {20'd0, irq_vector}, 32'h400);
    // R9: acknowledge with status bit 1 pending
    cycle('0, 16'd0, 1'b1, 1'b0, 2'd0, 32'd0, 1'b1, "R9 ack");
    chk("R9 strobe high", {31'd0, timer_capture}, 32'd1);
    idle(2'd0, 1'b1, "R9 after");
    chk("R9 strobe one cycle", {31'd0, timer_capture}, 32'd0);

    // random traffic against the model
    for (int i = 0; i < 4000; i++) begin
      logic [1:0]  a;
      logic        wr;
      logic [31:0] wd;
      a  = 2'($urandom_range(0, 3));
      wr = ($urandom_range(0, 9) < 3);
      wd = $urandom & $urandom;
      if (a == 2'd3) wd = {8'd0, 8'($urandom_range(0, 2)), 16'h1201};
      cycle(GL'($urandom & $urandom & $urandom), 16'($urandom & $urandom & $urandom),
            ($urandom_range(0, 7) != 0), wr, a, wd, ($urandom_range(0, 3) == 0),
            "random");
    end

    done = 1'b1;
    summary();
    $finish;
  end
endmodule